// File: doc/BRIEF.md
# Dual-Clock Toggle-Flag FIFO

A shallow first-in first-out buffer that carries data words from a write clock domain into an unrelated read clock domain. Storage is a small register array. Pointers never leave their own domain. Instead, every storage cell has two single-bit toggle flags. The writer owns one flag and the reader owns the other.

A write inverts the writer's flag for the addressed cell. A read inverts the reader's flag for the cell it consumes. A cell holds unread data exactly when its two flags disagree.

Each domain receives the other side's flags through a two-stage synchronizer. It then judges occupancy from the cell at its own pointer and the cell after it. A crossing that is still in flight can only make the status more cautious: the write side may see a cell as still occupied, and the read side may see a cell as still empty.

The block suits short, latency-sensitive domain crossings, or a front stage that feeds a deeper single-clock buffer.

Top module: `toggle_flag_fifo`

## Requirements
- R1: While either reset is high and immediately after both are released, `rempty` is 1 and `wfull`, `wlast` and `rlast` are 0.
- R2: Words leave at `rdata` in exactly the order in which accepted writes delivered them, with no loss and no duplication.
- R3: With no reads, DEPTH accepted writes set `wfull` to 1 on the first write clock edge after the last of them. A write is accepted when `wput` is 1 and `wfull` is 0 at a write clock edge.
- R4: `wlast` is 1 exactly when the cell at the write pointer is free and the following cell is still occupied, as seen by the write side. Starting from empty, after DEPTH-1 writes with no reads, `wlast` is 1 and `wfull` is 0.
- R5: A write attempted while `wfull` is 1 is ignored. It stores nothing, and the word never appears at the read port.
- R6: A read attempted while `rempty` is 1 is ignored. The next word written is the next word delivered.
- R7: `rlast` is 1 exactly when the read side sees the cell at its pointer occupied and the following cell empty.
- R8: An accepted write clears `rempty` no later than the third read clock rising edge after the write edge. A read taken while full clears `wfull` no later than the third write clock rising edge after the read edge.
- R9: While `rempty` is 0, `rdata` shows the oldest unread word combinationally. It holds steady until that word is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write domain clock |
| wrst | input | 1 | Write domain synchronous reset, active high |
| wput | input | 1 | Write request |
| wdata | input | WIDTH | Word to store |
| wfull | output | 1 | No free cell at the write pointer |
| wlast | output | 1 | Exactly one free cell remains before full |
| rclk | input | 1 | Read domain clock |
| rrst | input | 1 | Read domain synchronous reset, active high |
| rtake | input | 1 | Read request, consumes the word on `rdata` |
| rdata | output | WIDTH | Oldest unread word |
| rempty | output | 1 | No readable word at the read pointer |
| rlast | output | 1 | Exactly one readable word is visible |

## Verification
A flag toggled twice, or a pointer that moves on an ignored request, breaks the pairing between cells and flags. This shows up at the read port within a few words, as a repeated, skipped or stale value. It can also show up as a phantom word after the buffer has drained.

A synchronizer stage that is missing or doubled shifts the moment `rempty` falls or `wfull` clears by one or more receiving-clock edges, so the crossing latency is measured at the ports. A wrong neighbour cell in the status decode makes `wlast` or `rlast` wrong at the exact fill levels of DEPTH-1 words and one word.

// File: rtl/toggle_flag_fifo.sv
module toggle_flag_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wput,
  input  logic [WIDTH-1:0] wdata,
  output logic             wfull,
  output logic             wlast,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             rtake,
  output logic [WIDTH-1:0] rdata,
  output logic             rempty,
  output logic             rlast
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] wtog, rtog;
  logic [DEPTH-1:0] rtog_m, rtog_w;
  logic [DEPTH-1:0] wtog_m, wtog_r;
  logic [AW-1:0]    wptr, rptr;

  wire [DEPTH-1:0] wbusy  = wtog ^ rtog_w;
  wire [DEPTH-1:0] rready = wtog_r ^ rtog;
  wire [AW-1:0]    wnext  = step(wptr);
  wire [AW-1:0]    rnext  = step(rptr);
  wire             wgo    = wput && !wfull;
  wire             rgo    = rtake && !rempty;

  assign wfull  = wbusy[wptr];
  assign wlast  = !wbusy[wptr] && wbusy[wnext];
  assign rempty = !rready[rptr];
  assign rlast  = rready[rptr] && !rready[rnext];
  assign rdata  = mem[rptr];

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wtog   <= '0;
      wptr   <= '0;
      rtog_m <= '0;
      rtog_w <= '0;
    end else begin
      rtog_m <= rtog;
      rtog_w <= rtog_m;
      if (wgo) begin
        wtog[wptr] <= ~wtog[wptr];
        wptr       <= wnext;
      end
    end
  end

  always_ff @(posedge wclk)
    if (wgo) mem[wptr] <= wdata;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rtog   <= '0;
      rptr   <= '0;
      wtog_m <= '0;
      wtog_r <= '0;
    end else begin
      wtog_m <= wtog;
      wtog_r <= wtog_m;
      if (rgo) begin
        rtog[rptr] <= ~rtog[rptr];
        rptr       <= rnext;
      end
    end
  end

  // R5
  write_ignored_chk: assert property (@(posedge wclk) disable iff (wrst)
    (wput && wfull) |=> ($stable(wptr) && $stable(wtog)));

  // R6
  read_ignored_chk: assert property (@(posedge rclk) disable iff (rrst)
    (rtake && rempty) |=> ($stable(rptr) && $stable(rtog)));

  // R3
  write_advance_chk: assert property (@(posedge wclk) disable iff (wrst)
    (wput && !wfull) |=> !$stable(wptr));

  // R9
  rdata_hold_chk: assert property (@(posedge rclk) disable iff (rrst || wrst)
    (!rempty && !rtake) |=> (!rempty && $stable(rdata)));
endmodule

// File: tb/toggle_flag_fifo_test.sv
module toggle_flag_fifo_test;
  localparam int W = 8;
  localparam int D = 8;
  localparam int NRAND = 400;

  logic wclk = 0, rclk = 0, wrst = 1, rrst = 1;
  logic wput = 0, rtake = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic wfull, wlast, rempty, rlast;

  int vecs = 0, errs = 0;
  logic [W-1:0] q[$];

  toggle_flag_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .wclk(wclk), .wrst(wrst), .wput(wput), .wdata(wdata),
    .wfull(wfull), .wlast(wlast),
    .rclk(rclk), .rrst(rrst), .rtake(rtake), .rdata(rdata),
    .rempty(rempty), .rlast(rlast));

  always #4 wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'(8'h10 + i * 3);
  endfunction

  task automatic wr(input logic [W-1:0] d);
    @(negedge wclk); wdata = d; wput = 1;
    @(negedge wclk); wput = 0;
  endtask

  task automatic rd(output logic [W-1:0] d);
    @(negedge rclk); d = rdata; rtake = 1;
    @(negedge rclk); rtake = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : main
    logic [W-1:0] d;
    int n;
    int wdone, rdone;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge rclk);
    chk(rempty == 1 && wfull == 0, "R1 in reset", {rempty, wfull}, 2'b10);
    @(negedge wclk); wrst = 0;
    @(negedge rclk); rrst = 0;
    settle();
    chk(rempty == 1 && rlast == 0, "R1 read side", {rempty, rlast}, 2'b10);
    chk(wfull == 0 && wlast == 0, "R1 write side", {wfull, wlast}, 2'b00);

    // R8 and R9 on a single word; R7 with one word visible
    wr(8'hA5);
    n = 0;
    while (rempty && n < 6) begin @(negedge rclk); n++; end
    chk(n <= 3 && !rempty, "R8 write to nonempty latency", n, 3);
    chk(rdata == 8'hA5, "R9 rdata shows word", rdata, 8'hA5);
    chk(rlast == 1, "R7 one word visible", rlast, 1);
    rd(d);
    settle();
    chk(rempty == 1 && rlast == 0, "R1 drained again", {rempty, rlast}, 2'b10);

    // R4: DEPTH-1 words leave one free cell
    for (int i = 0; i < D - 1; i++) wr(pat(i));
    chk(wlast == 1 && wfull == 0, "R4 one slot left", {wlast, wfull}, 2'b10);
    wr(pat(D - 1));
    chk(wfull == 1 && wlast == 0, "R3 full after DEPTH writes", {wfull, wlast}, 2'b10);
    wr(8'hEE);  // R5: attempt while full
    settle();
    chk(wfull == 1, "R5 still full after ignored write", wfull, 1);
    for (int i = 0; i < D; i++) begin
      if (i == D - 1) chk(rlast == 1, "R7 last word flagged", rlast, 1);
      else chk(rlast == 0, "R7 not last", rlast, 0);
      rd(d);
      chk(d == pat(i), "R2 order after fill", d, pat(i));
    end
    settle();
    chk(rempty == 1, "R5 ignored write not stored", rempty, 1);
    chk(wfull == 0 && wlast == 0, "R3 free after drain", {wfull, wlast}, 2'b00);

    // R6: read while empty
    @(negedge rclk); rtake = 1;
    @(negedge rclk); rtake = 0;
    wr(8'h5C);
    settle();
    rd(d);
    chk(d == 8'h5C, "R6 ignored read skips nothing", d, 8'h5C);
    settle();

    // R8 write side: fill, take one, watch full clear
    for (int i = 0; i < D; i++) wr(pat(i + 20));
    settle();
    chk(wfull == 1, "R3 full again", wfull, 1);
    rd(d);
    chk(d == pat(20), "R2 first out", d, pat(20));
    n = 0;
    while (wfull && n < 6) begin @(negedge wclk); n++; end
    chk(n <= 3 && !wfull, "R8 read to not-full latency", n, 3);
    for (int i = 1; i < D; i++) begin
      rd(d);
      chk(d == pat(i + 20), "R2 drain order", d, pat(i + 20));
    end
    settle();

    // random traffic with attempts while full or empty (R5, R6)
    wdone = 0; rdone = 0;
    fork
      begin
        while (wdone < NRAND) begin
          @(negedge wclk);
          wput = 0;
          if ($urandom % 3 != 0) begin
            wdata = W'($urandom);
            wput = 1;
            if (!wfull) begin q.push_back(wdata); wdone++; end
          end
        end
        @(negedge wclk); wput = 0;
      end
      begin
        while (rdone < NRAND) begin
          @(negedge rclk);
          rtake = 0;
          if (!rempty) begin
            if (q.size() == 0) chk(0, "R2 phantom word", rdata, 0);
            else begin
              chk(rdata == q[0], "R2 random order", rdata, q[0]);
              if ($urandom % 4 != 0) begin
                rtake = 1;
                void'(q.pop_front());
                rdone++;
              end
            end
          end else if ($urandom % 2 == 0) rtake = 1;
        end
        @(negedge rclk); rtake = 0;
      end
    join
    settle();
    chk(rempty == 1 && q.size() == 0, "R2 all delivered", rempty, 1);
    finish_run();
  end
endmodule